// File: doc/BRIEF.md
# Interlaced Raster Beam Timing Generator

This block keeps the horizontal and vertical beam position of a raster video system, both counted on a master-clock enable. The horizontal counter counts master cycles within a scanline. The vertical counter counts scanlines within a field. A field parity bit changes at every frame wrap. The parity bit decides two length changes. In interlace mode the even field gets one extra scanline. In non-interlace mode one chosen scanline of the odd field loses one dot.

The block also produces the vertical-blank window and a status flag that marks the start of that window. When enabled, it raises an interrupt request a fixed number of cycles into the first blanking line. A status-read strobe clears both the flag and the request. A separate single-cycle strobe marks where the memory refresh falls on each line. That position moves between an early and a late cycle on every new line, except on the shortened line. A frame toggle bit flips once per frame.

The mode selects are captured only at the frame wrap, so a frame never changes length partway through.

Top module: `beam_timer`

## Requirements
- R1: While `ce` is high, `hCount` goes up by one per clock and returns to 0 after the last cycle of the line. A normal line lasts DOTS_PER_LINE×DOT_CYCLES cycles. While `ce` is low, `hCount` and `vCount` hold their values.
- R2: `vCount` runs from 0 to the frame's line count minus 1. With interlace off, that count is NTSC_LINES, or PAL_LINES when the PAL select was high at the last frame wrap.
- R3: `fieldOdd` inverts each time `vCount` wraps to 0.
- R4: With interlace captured, a frame whose `fieldOdd` is 0 has one line more than the base count. A frame whose `fieldOdd` is 1 keeps the base count.
- R5: With interlace off, line SHORT_LINE has DOT_CYCLES fewer cycles when `fieldOdd` is 1. With interlace on, every line is full length.
- R6: The refresh position starts at REFRESH_LATE. It switches between REFRESH_EARLY and REFRESH_LATE at the start of every line except the shortened line. `refreshPulse` is high for one clock, when `ce` is high and `hCount` equals the position.
- R7: `vblank` rises when `vCount` reaches VBLANK_LINE, or VBLANK_LINE_OVS if overscan was captured. It stays high until the frame wrap.
- R8: `nmiFlag` is set when vblank starts. It is cleared by `statusRead` or by the frame wrap. If both happen in the same cycle, setting wins.
- R9: If `nmiEnable` is high when the vblank line begins, `nmiReq` rises on the clock at which `hCount` becomes NMI_DELAY. It holds until `statusRead` or the frame wrap.
- R10: `frameToggle` inverts at each frame wrap.
- R11: Changes to `interlaceSel`, `overscanSel` and `palSel` take effect only at the next frame wrap.
- R12: Reset clears both counters, `fieldOdd`, `vblank`, `nmiFlag`, `nmiReq` and `frameToggle`. The first frame after reset is a base-length frame with interlace off and overscan off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Master-cycle enable |
| interlaceSel | input | 1 | Interlace mode select |
| overscanSel | input | 1 | Late vblank start select |
| palSel | input | 1 | Select the PAL line count |
| nmiEnable | input | 1 | Vblank interrupt enable |
| statusRead | input | 1 | Status-read strobe; clears flag and request |
| hCount | output | HW | Master cycle within the line |
| vCount | output | VW | Line within the field |
| fieldOdd | output | 1 | Field parity |
| vblank | output | 1 | Vertical blanking active |
| nmiReq | output | 1 | Vblank interrupt request |
| nmiFlag | output | 1 | Vblank-start status flag |
| frameToggle | output | 1 | Inverts once per frame |
| refreshPulse | output | 1 | Memory refresh strobe |

## Verification
The bench shrinks the raster so that it can run many frames in a short simulation:
- 8 dots of 4 cycles per line
- 20 NTSC lines or 24 PAL lines
- shortened line 12
- vblank starting at line 14, or line 16 with overscan
- refresh positions 5 and 9
- interrupt delay 12

With these values, a few thousand clocks cover both field parities, the shortened line, the extra interlace line, both refresh positions and mode changes made mid-frame. The early and late vblank starts and interrupt frames with the enable on and off also fall within that span. A gated enable pattern makes every counter hold at random points within the line.

// File: rtl/beam_pkg.sv
package beam_pkg;
  // Strobes from control to datapath for one master cycle
  typedef struct packed {
    logic advance;   // master-cycle enable
    logic lineEnd;   // last cycle of the current line
    logic frameEnd;  // last cycle of the last line
  } beamStrobe_t;
endpackage

// File: rtl/beam_dpath.sv
module beam_dpath
  import beam_pkg::*;
#(
  parameter int DOT_CYCLES    = 4,
  parameter int DOTS_PER_LINE = 341,
  parameter int NTSC_LINES    = 262,
  parameter int PAL_LINES     = 312,
  parameter int SHORT_LINE    = 240,
  parameter int REFRESH_EARLY = 534,
  parameter int REFRESH_LATE  = 538,
  parameter int HW            = 11,
  parameter int VW            = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  beamStrobe_t   strb,
  input  logic          interlaceSel,
  input  logic          overscanSel,
  input  logic          palSel,
  output logic [HW-1:0] hCount,
  output logic [HW-1:0] lineLen,
  output logic [HW-1:0] refreshPos,
  output logic [VW-1:0] vCount,
  output logic [VW-1:0] frameLines,
  output logic          fieldOdd,
  output logic          ilaceLatched,
  output logic          ovsLatched,
  output logic          refreshPulse
);
  localparam int FULL = DOTS_PER_LINE * DOT_CYCLES;
  localparam logic [HW-1:0] FULL_LEN  = HW'(FULL);
  localparam logic [HW-1:0] SHORT_LEN = HW'(FULL - DOT_CYCLES);
  localparam logic [HW-1:0] REF_EARLY = HW'(REFRESH_EARLY);
  localparam logic [HW-1:0] REF_LATE  = HW'(REFRESH_LATE);
  localparam logic [VW-1:0] NTSC_V    = VW'(NTSC_LINES);
  localparam logic [VW-1:0] PAL_V     = VW'(PAL_LINES);
  localparam logic [VW-1:0] SHORT_V   = VW'(SHORT_LINE);

  logic [VW-1:0] vNext;
  logic [VW-1:0] linesNext;
  logic          fieldNext;
  logic          shortNext;

  always_comb begin
    vNext     = vCount + 1'b1;
    fieldNext = ~fieldOdd;
    // the line after a wrap is line 0, never the shortened one
    shortNext = !strb.frameEnd && (vNext == SHORT_V) && !ilaceLatched && fieldOdd;
    linesNext = (palSel ? PAL_V : NTSC_V) + VW'(interlaceSel && !fieldNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount       <= '0;
      vCount       <= '0;
      fieldOdd     <= 1'b0;
      lineLen      <= FULL_LEN;
      frameLines   <= NTSC_V;
      ilaceLatched <= 1'b0;
      ovsLatched   <= 1'b0;
      refreshPos   <= REF_LATE;
    end else if (strb.advance) begin
      if (strb.lineEnd) begin
        hCount  <= '0;
        lineLen <= shortNext ? SHORT_LEN : FULL_LEN;
        if (!shortNext)
          refreshPos <= (refreshPos == REF_LATE) ? REF_EARLY : REF_LATE;
        if (strb.frameEnd) begin
          vCount       <= '0;
          fieldOdd     <= fieldNext;
          ilaceLatched <= interlaceSel;
          ovsLatched   <= overscanSel;
          frameLines   <= linesNext;
        end else begin
          vCount <= vNext;
        end
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  assign refreshPulse = strb.advance && (hCount == refreshPos);
endmodule

// File: rtl/beam_ctrl.sv
module beam_ctrl
  import beam_pkg::*;
#(
  parameter int VBLANK_LINE     = 225,
  parameter int VBLANK_LINE_OVS = 240,
  parameter int NMI_DELAY       = 12,
  parameter int HW              = 11,
  parameter int VW              = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          nmiEnable,
  input  logic          statusRead,
  input  logic [HW-1:0] hCount,
  input  logic [HW-1:0] lineLen,
  input  logic [VW-1:0] vCount,
  input  logic [VW-1:0] frameLines,
  input  logic          ovsLatched,
  output beamStrobe_t   strb,
  output logic          vblank,
  output logic          nmiFlag,
  output logic          nmiReq,
  output logic          frameToggle
);
  localparam logic [VW-1:0] VB_V      = VW'(VBLANK_LINE);
  localparam logic [VW-1:0] VB_OVS_V  = VW'(VBLANK_LINE_OVS);
  localparam logic [HW-1:0] REQ_PRE_H = HW'(NMI_DELAY - 1);

  logic          armed;
  logic          vbStartHit;
  logic          reqHit;
  logic [VW-1:0] vNext;

  always_comb begin
    vNext         = vCount + 1'b1;
    strb.advance  = ce;
    strb.lineEnd  = (hCount == lineLen - 1'b1);
    strb.frameEnd = strb.lineEnd && (vCount == frameLines - 1'b1);
    vbStartHit    = ce && strb.lineEnd && !strb.frameEnd &&
                    (vNext == (ovsLatched ? VB_OVS_V : VB_V));
    reqHit        = ce && armed && !strb.lineEnd && (hCount == REQ_PRE_H);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vblank      <= 1'b0;
      nmiFlag     <= 1'b0;
      nmiReq      <= 1'b0;
      armed       <= 1'b0;
      frameToggle <= 1'b0;
    end else if (ce && strb.frameEnd) begin
      vblank      <= 1'b0;
      nmiFlag     <= 1'b0;
      nmiReq      <= 1'b0;
      armed       <= 1'b0;
      frameToggle <= ~frameToggle;
    end else begin
      if (vbStartHit) begin
        vblank  <= 1'b1;
        nmiFlag <= 1'b1;
        armed   <= nmiEnable;
      end else if (statusRead) begin
        nmiFlag <= 1'b0;
      end
      if (reqHit) begin
        nmiReq <= 1'b1;
        armed  <= 1'b0;
      end else if (statusRead) begin
        nmiReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/beam_timer.sv
module beam_timer
  import beam_pkg::*;
#(
  parameter int DOT_CYCLES      = 4,
  parameter int DOTS_PER_LINE   = 341,
  parameter int NTSC_LINES      = 262,
  parameter int PAL_LINES       = 312,
  parameter int SHORT_LINE      = 240,
  parameter int VBLANK_LINE     = 225,
  parameter int VBLANK_LINE_OVS = 240,
  parameter int REFRESH_EARLY   = 534,
  parameter int REFRESH_LATE    = 538,
  parameter int NMI_DELAY       = 12,
  localparam int HW = $clog2(DOTS_PER_LINE * DOT_CYCLES),
  localparam int VW = $clog2(PAL_LINES + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          interlaceSel,
  input  logic          overscanSel,
  input  logic          palSel,
  input  logic          nmiEnable,
  input  logic          statusRead,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          fieldOdd,
  output logic          vblank,
  output logic          nmiReq,
  output logic          nmiFlag,
  output logic          frameToggle,
  output logic          refreshPulse
);
  beamStrobe_t   strb;
  logic [HW-1:0] lineLen;
  logic [HW-1:0] refreshPos;
  logic [VW-1:0] frameLines;
  logic          ilaceLatched;
  logic          ovsLatched;

  beam_ctrl #(
    .VBLANK_LINE(VBLANK_LINE), .VBLANK_LINE_OVS(VBLANK_LINE_OVS),
    .NMI_DELAY(NMI_DELAY), .HW(HW), .VW(VW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .nmiEnable(nmiEnable), .statusRead(statusRead),
    .hCount(hCount), .lineLen(lineLen), .vCount(vCount), .frameLines(frameLines),
    .ovsLatched(ovsLatched), .strb(strb), .vblank(vblank), .nmiFlag(nmiFlag),
    .nmiReq(nmiReq), .frameToggle(frameToggle)
  );

  beam_dpath #(
    .DOT_CYCLES(DOT_CYCLES), .DOTS_PER_LINE(DOTS_PER_LINE), .NTSC_LINES(NTSC_LINES),
    .PAL_LINES(PAL_LINES), .SHORT_LINE(SHORT_LINE), .REFRESH_EARLY(REFRESH_EARLY),
    .REFRESH_LATE(REFRESH_LATE), .HW(HW), .VW(VW)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .interlaceSel(interlaceSel),
    .overscanSel(overscanSel), .palSel(palSel), .hCount(hCount), .lineLen(lineLen),
    .refreshPos(refreshPos), .vCount(vCount), .frameLines(frameLines),
    .fieldOdd(fieldOdd), .ilaceLatched(ilaceLatched), .ovsLatched(ovsLatched),
    .refreshPulse(refreshPulse)
  );
endmodule

// File: rtl/beam_timer_chk.sv
module beam_timer_chk #(
  parameter int DOT_CYCLES      = 4,
  parameter int DOTS_PER_LINE   = 341,
  parameter int NTSC_LINES      = 262,
  parameter int PAL_LINES       = 312,
  parameter int SHORT_LINE      = 240,
  parameter int VBLANK_LINE     = 225,
  parameter int VBLANK_LINE_OVS = 240,
  parameter int REFRESH_EARLY   = 534,
  parameter int REFRESH_LATE    = 538,
  parameter int NMI_DELAY       = 12,
  parameter int HW              = 11,
  parameter int VW              = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          ce,
  input logic          statusRead,
  input logic [HW-1:0] hCount,
  input logic [VW-1:0] vCount,
  input logic          fieldOdd,
  input logic          vblank,
  input logic          nmiReq,
  input logic          nmiFlag,
  input logic          frameToggle,
  input logic          refreshPulse,
  input logic [HW-1:0] lineLen,
  input logic [HW-1:0] refreshPos,
  input logic [VW-1:0] frameLines,
  input logic          ilaceLatched,
  input logic          ovsLatched
);
  localparam logic [HW-1:0] FULL_LEN = HW'(DOTS_PER_LINE * DOT_CYCLES);
  localparam logic [VW-1:0] NTSC_V   = VW'(NTSC_LINES);
  localparam logic [VW-1:0] PAL_V    = VW'(PAL_LINES);
  localparam logic [VW-1:0] SHORT_V  = VW'(SHORT_LINE);
  localparam logic [VW-1:0] VB_V     = VW'(VBLANK_LINE);
  localparam logic [VW-1:0] VBO_V    = VW'(VBLANK_LINE_OVS);

  logic atLineEnd, atFrameEnd;
  assign atLineEnd  = ce && (hCount == lineLen - 1'b1);
  assign atFrameEnd = atLineEnd && (vCount == frameLines - 1'b1);

  p_hstep_r1: assert property (@(posedge clk) disable iff (rst)
    ce && !atLineEnd |=> hCount == $past(hCount) + 1'b1);
  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    atLineEnd |=> hCount == '0);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(hCount) && $stable(vCount));
  p_vwrap_r2: assert property (@(posedge clk) disable iff (rst)
    atFrameEnd |=> vCount == '0);
  p_field_r3: assert property (@(posedge clk) disable iff (rst)
    atFrameEnd |=> fieldOdd != $past(fieldOdd));
  p_lines_r4: assert property (@(posedge clk) disable iff (rst)
    (frameLines != NTSC_V && frameLines != PAL_V) |-> ilaceLatched && !fieldOdd);
  p_short_r5: assert property (@(posedge clk) disable iff (rst)
    (lineLen != FULL_LEN) |-> vCount == SHORT_V && fieldOdd && !ilaceLatched);
  p_refpos_r6: assert property (@(posedge clk) disable iff (rst)
    refreshPos == HW'(REFRESH_EARLY) || refreshPos == HW'(REFRESH_LATE));
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    refreshPulse |=> !refreshPulse);
  p_vblank_r7: assert property (@(posedge clk) disable iff (rst)
    vblank == (vCount >= (ovsLatched ? VBO_V : VB_V)));
  p_flagfall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(nmiFlag) |-> $past(statusRead) || vCount == '0);
  p_nmirise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(nmiReq) |-> vblank && hCount == HW'(NMI_DELAY));
  p_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    atFrameEnd |=> frameToggle != $past(frameToggle));
endmodule

bind beam_timer beam_timer_chk #(
  .DOT_CYCLES(DOT_CYCLES), .DOTS_PER_LINE(DOTS_PER_LINE), .NTSC_LINES(NTSC_LINES),
  .PAL_LINES(PAL_LINES), .SHORT_LINE(SHORT_LINE), .VBLANK_LINE(VBLANK_LINE),
  .VBLANK_LINE_OVS(VBLANK_LINE_OVS), .REFRESH_EARLY(REFRESH_EARLY),
  .REFRESH_LATE(REFRESH_LATE), .NMI_DELAY(NMI_DELAY), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .statusRead(statusRead), .hCount(hCount),
  .vCount(vCount), .fieldOdd(fieldOdd), .vblank(vblank), .nmiReq(nmiReq),
  .nmiFlag(nmiFlag), .frameToggle(frameToggle), .refreshPulse(refreshPulse),
  .lineLen(lineLen), .refreshPos(refreshPos), .frameLines(frameLines),
  .ilaceLatched(ilaceLatched), .ovsLatched(ovsLatched)
);

// File: tb/beam_timer_tb.sv
`timescale 1ns/1ps
module beam_timer_tb;
  localparam int DOT = 4, DOTS = 8, NTSC = 20, PAL = 24, SHORTL = 12;
  localparam int VB = 14, VBO = 16, REFE = 5, REFL = 9, NDLY = 12;
  localparam int FULL = DOT * DOTS;

  logic clk = 1'b0;
  logic rst, ce, interlaceSel, overscanSel, palSel, nmiEnable, statusRead;
  logic [4:0] hCount;
  logic [4:0] vCount;
  logic fieldOdd, vblank, nmiReq, nmiFlag, frameToggle, refreshPulse;

  always #2.5 clk = ~clk;

  beam_timer #(
    .DOT_CYCLES(DOT), .DOTS_PER_LINE(DOTS), .NTSC_LINES(NTSC), .PAL_LINES(PAL),
    .SHORT_LINE(SHORTL), .VBLANK_LINE(VB), .VBLANK_LINE_OVS(VBO),
    .REFRESH_EARLY(REFE), .REFRESH_LATE(REFL), .NMI_DELAY(NDLY)
  ) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .interlaceSel(interlaceSel), .overscanSel(overscanSel),
    .palSel(palSel), .nmiEnable(nmiEnable), .statusRead(statusRead), .hCount(hCount),
    .vCount(vCount), .fieldOdd(fieldOdd), .vblank(vblank), .nmiReq(nmiReq),
    .nmiFlag(nmiFlag), .frameToggle(frameToggle), .refreshPulse(refreshPulse)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model
  int mh, mv, mField, mIlace, mOvs, mLines, mLen, mRef, mVb, mFlag, mReq, mArm, mTog;
  int mDoneLines = 0, sf, sr;

  always @(posedge clk) begin
    if (rst) begin
      mh = 0; mv = 0; mField = 0; mIlace = 0; mOvs = 0; mLines = NTSC; mLen = FULL;
      mRef = REFL; mVb = 0; mFlag = 0; mReq = 0; mArm = 0; mTog = 0;
    end else begin
      sf = 0; sr = 0;
      if (ce) begin
        if (mh == mLen - 1) begin
          mh = 0;
          if (mv == mLines - 1) begin
            mDoneLines = mLines;
            mv = 0; mField = 1 - mField;
            mIlace = interlaceSel; mOvs = overscanSel;
            mLines = (palSel ? PAL : NTSC) + ((mIlace == 1 && mField == 0) ? 1 : 0);
            mVb = 0; mFlag = 0; mReq = 0; mArm = 0; mTog = 1 - mTog;
            mLen = FULL; mRef = (mRef == REFL) ? REFE : REFL;
          end else begin
            mv = mv + 1;
            if (mv == SHORTL && mIlace == 0 && mField == 1) mLen = FULL - DOT;
            else begin mLen = FULL; mRef = (mRef == REFL) ? REFE : REFL; end
            if (mv == (mOvs ? VBO : VB)) begin
              mVb = 1; mFlag = 1; sf = 1; mArm = nmiEnable;
            end
          end
        end else begin
          mh = mh + 1;
          if (mArm == 1 && mh == NDLY) begin mReq = 1; sr = 1; mArm = 0; end
        end
      end
      if (statusRead && sf == 0) mFlag = 0;
      if (statusRead && sr == 0) mReq = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int prevH = 0, prevV = 0;

  task automatic compareAll();
    int expLen;
    chk((mLen != FULL) ? "R5" : "R1", "hCount", hCount, mh);
    chk("R2", "vCount", vCount, mv);
    chk("R3", "fieldOdd", fieldOdd, mField);
    chk("R7", "vblank", vblank, mVb);
    chk("R8", "nmiFlag", nmiFlag, mFlag);
    chk("R9", "nmiReq", nmiReq, mReq);
    chk("R10", "frameToggle", frameToggle, mTog);
    chk("R6", "refreshPulse", refreshPulse, (ce && mh == mRef) ? 1 : 0);
    if (hCount < prevH) begin
      expLen = (prevV == SHORTL && mIlace == 0 && mField == 1) ? FULL - DOT : FULL;
      chk("R5", "measured line length", prevH + 1, expLen);
    end
    if (vCount == 0 && prevV != 0)
      chk("R2 R4 R11", "measured frame lines", prevV + 1, mDoneLines);
    prevH = hCount; prevV = vCount;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      ce = (cyc % 7) != 3;
      statusRead = (cyc % 173) == 0;
      cyc++;
    end
  endtask

  initial begin
    rst = 1; ce = 0; interlaceSel = 1; overscanSel = 1; palSel = 1;
    nmiEnable = 1; statusRead = 0;
    repeat (3) @(negedge clk);
    chk("R12", "reset hCount", hCount, 0);
    chk("R12", "reset vCount", vCount, 0);
    chk("R12", "reset fieldOdd", fieldOdd, 0);
    chk("R12", "reset vblank", vblank, 0);
    chk("R12", "reset nmiFlag", nmiFlag, 0);
    chk("R12", "reset nmiReq", nmiReq, 0);
    chk("R12", "reset frameToggle", frameToggle, 0);
    rst = 0;
    // first frame: base NTSC non-interlace despite selects (R12 R11)
    run(300);
    interlaceSel = 0; overscanSel = 0; palSel = 0;
    run(2200);                       // both parities, shortened line
    interlaceSel = 1; run(2300);     // extra line on even field
    palSel = 1; overscanSel = 1; nmiEnable = 0; run(1100);
    nmiEnable = 1; run(1500);
    interlaceSel = 0; run(2000);     // PAL non-interlace with short line
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule